// File: doc/BRIEF.md
# SPI Burst-Read Register Slave

This block answers burst reads from a small register bank over a four-wire SPI link (mode 0, eight-bit bytes, most significant bit first). A frame opens when chip select goes low. The master sends three command bytes: a start address, a filler byte whose value is ignored, and a count code that gives the burst length N. The slave replies in a fixed order. It first repeats the start address. It then sends N register values from consecutive addresses, wrapping at the end of the bank. After the data it sends the address of the last register it read, and it ends with a status byte.

The master proves the link is sound by handing every data byte back one byte slot later. The slave compares each returned byte with the byte it sent, and any difference latches an error. During the status byte the master sends the good status value in step with the slave. If a bit on the input differs from the bit being sent, the slave inverts the remaining bits of the status byte. A one-cycle completion pulse, with an error level beside it, reports each finished frame inside the chip. A simple synchronous write port loads the bank before the reads.

All serial inputs are sampled into the system clock domain, so the block runs on one clock.

Top module: `spi_burst_slave`

## Requirements
- R1: Synchronous reset drives `spi_miso`, `frame_done` and `frame_err` low.
- R2: Serial-out stays low while chip select is high and during the three command bytes. Input bits are sampled on rising SCLK and output bits change on falling SCLK, most significant bit first.
- R3: The first reply byte is the start address. Only the low five bits of the address byte are used, and the upper three bits of the reply are zero.
- R4: The count byte is decoded as N = high nibble + 1. A low nibble that is not the bitwise inverse of the high nibble marks the frame as failed, and the burst still runs for N bytes. For example, 0x3C gives N = 4 and 0x3D gives N = 4 with an error.
- R5: The data bytes are the registers at start, start+1, and so on up to start+N-1, with addresses taken modulo 32.
- R6: After the data, the slave sends (start+N-1) modulo 32, zero-extended to a byte.
- R7: In the slot after each data byte, the master returns that byte on serial-in. A returned byte that differs from the one sent latches the error. This covers the last data byte, which is returned during the end-address slot.
- R8: The status byte is 0x59 when no error is latched as it begins, and 0xA6 otherwise.
- R9: During the status byte, each serial-in bit is compared with the serial-out bit at the same rising edge. On the first mismatch, all later bits of the byte are inverted and the error latches.
- R10: A one-cycle `frame_done` pulse follows the eighth status bit. `frame_err` then holds the error of that frame until the next completion.
- R11: Raising chip select before the status byte ends aborts the frame without a `frame_done` pulse and clears the error, so the next frame starts clean.
- R12: A write on the preload port changes the value that later bursts return for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, held low when idle |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 5 | Preload register address |
| pl_data | input | 8 | Preload write data |
| frame_done | output | 1 | One-cycle pulse when a frame completes |
| frame_err | output | 1 | Error result of the last completed frame |

## Verification
The properties assume the following about the inputs. Each SCLK level lasts at least four system clocks. Chip select falls at least one half period before the first rising SCLK edge. Serial-in changes only while SCLK is low. Under these conditions the synchronizers deliver clean edges and the bank read settles before the next falling edge. The bench holds each SCLK level for eight system clocks. It moves serial-in and chip select only in the low phase of SCLK and leaves a full half period after chip select falls. Its frames include a bad count code, corrupted echoes in the middle and at the end of a burst, a flipped status bit, and an abort at a byte boundary.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CNT_W  = NIB_W + 1;
  localparam logic [BYTE_W-1:0] STAT_OK  = 8'h59;
  localparam logic [BYTE_W-1:0] STAT_BAD = 8'hA6;

  typedef enum logic [2:0] {
    IDLE, RX_ADDR, RX_NOP, RX_COUNT, TX_ADDR, TX_DATA, TX_ENDADDR, TX_STATUS
  } state_t;
endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sbs_regbank.sv
module sbs_regbank #(
  parameter int DEPTH = 32,
  parameter int DW = 8,
  parameter int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              miso,
  output logic              frame_done,
  output logic              frame_err,
  output state_t            st_o,
  output logic              err_o,
  output logic              cs_act_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  state_t             st;
  logic               sclk_d, armed, load_pend, err, chk_en;
  logic [2:0]         bit_cnt;
  logic [BYTE_W-1:0]  rx_sh, tx_sh, sent_cur, sent_prev, next_tx, rx_byte;
  logic [ADDR_W-1:0]  cur_addr, start_addr;
  logic [CNT_W-1:0]   remain;
  logic               rise, fall, byte_end, cs_act, stat_miss, cnt_bad;

  assign cs_act    = ~cs_n_s;
  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign byte_end  = rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_s};
  assign stat_miss = (st == TX_STATUS) && (mosi_s != tx_sh[BYTE_W-1]);
  assign cnt_bad   = rx_byte[NIB_W-1:0] != ~rx_byte[BYTE_W-1:NIB_W];

  // Byte placed on the wire at the falling edge after a slot boundary.
  always_comb begin
    next_tx = '0;
    case (st)
      TX_ADDR:    next_tx[ADDR_W-1:0] = start_addr;
      TX_DATA:    next_tx = rd_data;
      TX_ENDADDR: next_tx[ADDR_W-1:0] = cur_addr;
      TX_STATUS:  next_tx = err ? STAT_BAD : STAT_OK;
      default:    next_tx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      sclk_d     <= 1'b0;
      armed      <= 1'b0;
      load_pend  <= 1'b0;
      err        <= 1'b0;
      chk_en     <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_sh      <= '0;
      sent_cur   <= '0;
      sent_prev  <= '0;
      cur_addr   <= '0;
      start_addr <= '0;
      remain     <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      sclk_d     <= sclk_s;
      frame_done <= 1'b0;
      if (!cs_act) begin
        st        <= IDLE;
        armed     <= 1'b1;
        err       <= 1'b0;
        bit_cnt   <= '0;
        tx_sh     <= '0;
        load_pend <= 1'b0;
      end else if (st == IDLE) begin
        if (armed) begin
          st      <= RX_ADDR;
          armed   <= 1'b0;
          err     <= 1'b0;
          bit_cnt <= '0;
        end
      end else if (rise) begin
        rx_sh   <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (stat_miss && !err) begin
          err <= 1'b1;
          tx_sh[BYTE_W-2:0] <= ~tx_sh[BYTE_W-2:0];
        end
        if (byte_end) begin
          load_pend <= 1'b1;
          case (st)
            RX_ADDR: begin
              start_addr <= rx_byte[ADDR_W-1:0];
              cur_addr   <= rx_byte[ADDR_W-1:0];
              st         <= RX_NOP;
            end
            RX_NOP: st <= RX_COUNT;
            RX_COUNT: begin
              remain <= CNT_W'(rx_byte[BYTE_W-1:NIB_W]) + CNT_W'(1);
              if (cnt_bad) err <= 1'b1;
              chk_en <= 1'b0;
              st     <= TX_ADDR;
            end
            TX_ADDR: st <= TX_DATA;
            TX_DATA: begin
              if (chk_en && (rx_byte != sent_prev)) err <= 1'b1;
              chk_en <= 1'b1;
              if (remain == CNT_W'(1)) begin
                st <= TX_ENDADDR;
              end else begin
                cur_addr <= (cur_addr == LAST_ADDR) ? '0 : cur_addr + 1'b1;
                remain   <= remain - CNT_W'(1);
              end
            end
            TX_ENDADDR: begin
              if (rx_byte != sent_prev) err <= 1'b1;
              st <= TX_STATUS;
            end
            TX_STATUS: begin
              st         <= IDLE;
              frame_done <= 1'b1;
              frame_err  <= err | stat_miss;
              tx_sh      <= '0;
              load_pend  <= 1'b0;
            end
            default: st <= IDLE;
          endcase
        end
      end else if (fall) begin
        if (load_pend) begin
          tx_sh     <= next_tx;
          sent_prev <= sent_cur;
          sent_cur  <= next_tx;
          load_pend <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso     = tx_sh[BYTE_W-1];
  assign rd_addr  = cur_addr;
  assign st_o     = st;
  assign err_o    = err;
  assign cs_act_o = cs_act;
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import sbs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              frame_done,
  output logic              frame_err
);
  logic [2:0]        pins_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;
  state_t            ctrl_st;
  logic              ctrl_err, ctrl_cs_act;

  sbs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q(pins_s)
  );

  sbs_regbank #(.DEPTH(DEPTH), .DW(BYTE_W), .AW(ADDR_W)) u_bank (
    .clk(clk), .we(pl_we), .waddr(pl_addr), .wdata(pl_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  sbs_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .sclk_s(pins_s[2]), .cs_n_s(pins_s[1]), .mosi_s(pins_s[0]),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .miso(spi_miso), .frame_done(frame_done), .frame_err(frame_err),
    .st_o(ctrl_st), .err_o(ctrl_err), .cs_act_o(ctrl_cs_act)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   spi_miso,
  input logic   frame_done,
  input logic   frame_err,
  input state_t st,
  input logic   err_flag,
  input logic   cs_act
);
  // R2: no output data while idle or receiving the command
  a_r2_quiet_in_cmd: assert property (@(posedge clk) disable iff (rst)
    (st inside {IDLE, RX_ADDR, RX_NOP, RX_COUNT}) |-> !spi_miso);

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R10: completion only follows the status slot
  a_r10_done_after_status: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(st) == TX_STATUS) && (st == IDLE));

  // R10: reported result equals the latched error
  a_r10_err_reported: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (frame_err == err_flag));

  // R7: error stays latched for the rest of a frame
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_flag && st != IDLE) |=> (err_flag || st == IDLE));

  // R11: chip select release aborts and clears
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> (st == IDLE) && !err_flag && !frame_done);
endmodule

bind spi_burst_slave sbs_checker u_chk (
  .clk(clk), .rst(rst), .spi_miso(spi_miso), .frame_done(frame_done),
  .frame_err(frame_err), .st(ctrl_st), .err_flag(ctrl_err), .cs_act(ctrl_cs_act)
);

// File: tb/spi_burst_slave_tb.sv
module spi_burst_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, done, ferr;
  logic pl_we = 1'b0;
  logic [4:0] pl_addr = '0;
  logic [7:0] pl_data = '0;

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  logic last_err = 1'b0;
  bit finished = 1'b0;
  logic [7:0] model [32];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  string tag_q [$];

  always #2.5 clk = ~clk;

  spi_burst_slave u_dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .frame_done(done), .frame_err(ferr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // Monitor: completion pulses and scoreboard of serial-out bytes
  always @(negedge clk) if (done) begin
    done_cnt++;
    last_err = ferr;
  end

  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0) begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  task automatic pl_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[a] = d;
  endtask

  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp, input string tag);
    logic [7:0] got;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int b = 7; b >= 0; b--) begin
      mosi = mo[b];
      repeat (HALF) @(negedge clk);
      got[b] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    got_q.push_back(got);
  endtask

  // bad_echo: data index 1..N whose returned copy is corrupted (0 = none)
  // flip_bit: status bit the master disturbs (-1 = none)
  // abort_at: byte slot before which chip select is released (-1 = none)
  task automatic run_frame(input logic [7:0] adr_b, input logic [7:0] cnt_b,
                           input int bad_echo, input int flip_bit, input int abort_at,
                           input string dtag, input string stag);
    int n, d0;
    bit cbad, err_exp, fin_err;
    logic [4:0] a0;
    logic [7:0] tx [18];
    logic [7:0] stat, mask, mo, ex;
    string tg;
    n = int'(cnt_b[7:4]) + 1;
    cbad = (cnt_b[3:0] != ~cnt_b[7:4]);
    a0 = adr_b[4:0];
    tx[0] = {3'b000, a0};
    for (int i = 1; i <= n; i++) tx[i] = model[5'(int'(a0) + i - 1)];
    tx[n+1] = {3'b000, 5'(int'(a0) + n - 1)};
    err_exp = cbad || (bad_echo != 0);
    if (err_exp) stat = 8'hA6;
    else if (flip_bit >= 0) begin
      mask = 8'hFF << flip_bit;
      stat = (8'h59 & mask) | (8'hA6 & ~mask);
    end else stat = 8'h59;
    fin_err = err_exp || (flip_bit >= 0);
    d0 = done_cnt;
    cs_n = 1'b0;
    repeat (2*HALF) @(negedge clk);
    for (int s = 0; s < n + 6; s++) begin
      if (abort_at >= 0 && s == abort_at) break;
      if (s == 0)      begin mo = adr_b;    ex = 8'h00; tg = "R2"; end
      else if (s == 1) begin mo = 8'h00;    ex = 8'h00; tg = "R2"; end
      else if (s == 2) begin mo = cnt_b;    ex = 8'h00; tg = "R2"; end
      else begin
        int k;
        k = s - 3;
        if (k == 0) begin mo = 8'h00; ex = tx[0]; tg = "R3"; end
        else if (k <= n + 1) begin
          mo = tx[k-1];
          if (k - 1 == bad_echo && bad_echo != 0) mo = mo ^ 8'h10;
          ex = tx[k];
          tg = (k == n + 1) ? "R6" : dtag;
        end else begin
          mo = (flip_bit >= 0) ? (8'h59 ^ (8'h01 << flip_bit)) : 8'h59;
          ex = stat; tg = stag;
        end
      end
      xfer(mo, ex, tg);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (30) @(negedge clk);
    if (abort_at >= 0) begin
      check(done_cnt == d0, "R11 no completion on abort", done_cnt - d0, 0);
    end else begin
      check(done_cnt == d0 + 1, "R10 one completion pulse", done_cnt - d0, 1);
      check(last_err == fin_err, {"R10 frame_err ", stag}, last_err, fin_err);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 act=hung exp=finished");
    summary();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miso == 1'b0, "R1 miso after reset", miso, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(ferr == 1'b0, "R1 err after reset", ferr, 0);
    for (int i = 0; i < 32; i++) pl_write(5'(i), 8'((i * 37 + 5) ^ 8'h5A));

    run_frame(8'h03, 8'h3C, 0, -1, -1, "R5", "R8");   // N=4 clean
    run_frame(8'h1E, 8'h4B, 0, -1, -1, "R5", "R8");   // wrap 30..2
    run_frame(8'h00, 8'hF0, 0, -1, -1, "R5", "R8");   // N=16
    run_frame(8'h07, 8'h0F, 0, -1, -1, "R5", "R8");   // N=1
    run_frame(8'hE5, 8'h1E, 0, -1, -1, "R3", "R8");   // upper address bits dropped
    run_frame(8'h04, 8'h3D, 0, -1, -1, "R4", "R4");   // bad count code, N=4
    run_frame(8'h08, 8'h4B, 2, -1, -1, "R7", "R7");   // mid-burst echo corrupted
    run_frame(8'h08, 8'h2D, 3, -1, -1, "R7", "R7");   // last echo corrupted
    run_frame(8'h0C, 8'h1E, 0, 4, -1, "R5", "R9");    // status bit disturbed
    run_frame(8'h02, 8'h3C, 0, -1, 5, "R11", "R11");  // abort mid-frame
    run_frame(8'h02, 8'h3C, 0, -1, -1, "R11", "R11"); // next frame clean
    pl_write(5'd10, 8'hC3);
    run_frame(8'h0A, 8'h1E, 0, -1, -1, "R12", "R8");  // preloaded value returned
    repeat (10) @(negedge clk);
    summary();
  end
endmodule